// File: doc/BRIEF.md
# Banked GPIO Port Register File

This block holds the runtime registers of a 32-pin general-purpose I/O unit. The registers sit in a 16-byte window of the host byte address space, and the window starts at a base address that the configuration logic supplies. The pins are grouped as four 8-bit ports. Every port has an output latch that drives its pins and an input register that captures the pin levels. The two lower ports also have an event-enable register and an event-status register. These detect rising edges on their inputs and combine into one event line.

The port blocks are not evenly spaced. The two event-capable ports take four bytes each. The two plain ports take two bytes each. The last four bytes of the window are reserved. Per-pin output enables come from configuration and pass straight to the pads. An enabled pin reads back its own driven value through the input register.

Top module: `gpio_portfile`

## Requirements
- R1: An access is decoded only when `bus_addr - base_addr` (modulo 2^ADDR_W) is below 16. Outside that window, reads return 0x00 and writes change nothing.
- R2: The output latches reset to 0x00, and a write sets them. A read at the latch offset returns the latched value, not the pin level. Pin n is driven from bit n[2:0] of port n[4:3], and `pin_oe` equals `cfg_oe`.
- R3: The input register holds the effective pin level. That level is the latched output where `cfg_oe` is 1 and `pin_in` elsewhere. It is seen three clock edges after a pin change (two synchronizer flops, then the register).
- R4: Port offsets from the base are 0, 4, 8 and 10. Inside a port, +0 is the output latch and +1 is the input register. On ports 0 and 1 only, +2 is event enable and +3 is event status. Enables reset to 0x00 and read back what was written.
- R5: A status bit is set when its synchronized input rises while its enable bit is 1. It is not set for a disabled bit or for a falling edge.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A set in the same cycle wins over a clear.
- R7: `event_irq` is 1 exactly when some status bit and its matching enable bit are both 1. Clearing the enable masks the line but keeps the status bit.
- R8: Offsets 12 to 15 read 0x00 and ignore writes. Writes to an input register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Host byte address |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| base_addr | input | ADDR_W | Window base from configuration |
| pin_in | input | 32 | Pad input levels (asynchronous) |
| cfg_oe | input | 32 | Per-pin output enable from configuration |
| pin_out | output | 32 | Pad drive values |
| pin_oe | output | 32 | Pad output enables |
| event_irq | output | 1 | OR of enabled, set event status bits |

## Verification
Read data is combinational, so a wrong decode or a wrong latch shows on `bus_rdata` in the same cycle the address is presented. A wrong latch also shows on `pin_out` one edge after the write. A fault in the synchronizer chain or in the input register moves the input readback away from its three-edge latency, or exposes a driven pin's own value incorrectly. Wrong event state shows on `event_irq` in the cycle the bad status bit is stored. That bit stays visible at the status offset until a write-one clears it.

// File: rtl/gpio_pf_pkg.sv
package gpio_pf_pkg;
    localparam int NPORT     = 4;
    localparam int PORT_W    = 8;
    localparam int NEVT      = 2;
    localparam int WIN_BYTES = 16;
    localparam int NPIN      = NPORT * PORT_W;
    localparam int OFF_W     = $clog2(WIN_BYTES);
    localparam int EVT_BITS  = NEVT * PORT_W;

    // Event-capable ports take four bytes each; the plain ports after them take two.
    function automatic logic [OFF_W-1:0] port_base(input int p);
        if (p < NEVT)
            return OFF_W'(4 * p);
        else
            return OFF_W'(4 * NEVT + 2 * (p - NEVT));
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = d;
        for (int s = 1; s < STAGES; s++)
            stg_d[s] = stg_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en_reg,
    input  logic         wr_st_reg,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] lvl_q,
    input  logic [W-1:0] lvl_d,
    output logic [W-1:0] en_q,
    output logic [W-1:0] st_q
);
    typedef struct packed {
        logic [W-1:0] en;
        logic [W-1:0] st;
    } evt_t;

    evt_t cur_q, nxt_d;
    logic [W-1:0] rise_d, clr_d;

    always_comb begin
        nxt_d  = cur_q;
        rise_d = lvl_d & ~lvl_q;
        clr_d  = wr_st_reg ? wdata : '0;
        if (wr_en_reg) nxt_d.en = wdata;
        // a new edge outranks a clear in the same cycle
        nxt_d.st = (cur_q.st & ~clr_d) | (cur_q.en & rise_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign en_q = cur_q.en;
    assign st_q = cur_q.st;
endmodule

// File: rtl/gpio_portfile.sv
module gpio_portfile
    import gpio_pf_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [31:0]       pin_in,
    input  logic [31:0]       cfg_oe,
    output logic [31:0]       pin_out,
    output logic [31:0]       pin_oe,
    output logic              event_irq
);
    typedef struct packed {
        logic [NPIN-1:0] out;
        logic [NPIN-1:0] inreg;
    } port_state_t;

    port_state_t state_d, state_q;

    logic [ADDR_W-1:0] rel;
    logic              in_win;
    logic [OFF_W-1:0]  off;
    logic [NPORT-1:0]  hit_out, hit_in;
    logic [NEVT-1:0]   hit_en, hit_st;
    logic [NPIN-1:0]   eff_lvl, sync_lvl;
    logic [EVT_BITS-1:0] en_all, st_all;

    assign rel    = bus_addr - base_addr;
    assign in_win = rel < ADDR_W'(WIN_BYTES);
    assign off    = rel[OFF_W-1:0];

    for (genvar p = 0; p < NPORT; p++) begin : g_port_dec
        assign hit_out[p] = in_win && (off == port_base(p));
        assign hit_in[p]  = in_win && (off == port_base(p) + OFF_W'(1));
    end

    for (genvar e = 0; e < NEVT; e++) begin : g_evt
        assign hit_en[e] = in_win && (off == port_base(e) + OFF_W'(2));
        assign hit_st[e] = in_win && (off == port_base(e) + OFF_W'(3));

        gpio_evt_bank #(.W(PORT_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en_reg (bus_wr && hit_en[e]),
            .wr_st_reg (bus_wr && hit_st[e]),
            .wdata     (bus_wdata),
            .lvl_q     (state_q.inreg[e*PORT_W +: PORT_W]),
            .lvl_d     (sync_lvl[e*PORT_W +: PORT_W]),
            .en_q      (en_all[e*PORT_W +: PORT_W]),
            .st_q      (st_all[e*PORT_W +: PORT_W])
        );
    end

    // a driven pin reads back its own drive value
    assign eff_lvl = (cfg_oe & state_q.out) | (~cfg_oe & pin_in);

    gpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (eff_lvl),
        .q     (sync_lvl)
    );

    always_comb begin
        state_d       = state_q;
        state_d.inreg = sync_lvl;
        for (int p = 0; p < NPORT; p++)
            if (bus_wr && hit_out[p])
                state_d.out[p*PORT_W +: PORT_W] = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (hit_out[p]) bus_rdata = state_q.out[p*PORT_W +: PORT_W];
            if (hit_in[p])  bus_rdata = state_q.inreg[p*PORT_W +: PORT_W];
        end
        for (int e = 0; e < NEVT; e++) begin
            if (hit_en[e]) bus_rdata = en_all[e*PORT_W +: PORT_W];
            if (hit_st[e]) bus_rdata = st_all[e*PORT_W +: PORT_W];
        end
    end

    assign pin_out   = state_q.out;
    assign pin_oe    = cfg_oe;
    assign event_irq = |(en_all & st_all);
endmodule

// File: rtl/gpio_portfile_chk.sv
module gpio_portfile_chk #(
    parameter int ADDR_W = 16,
    parameter int EW     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic [ADDR_W-1:0] base_addr,
    input logic [31:0]       pin_out,
    input logic              event_irq,
    input logic [EW-1:0]     evt_en,
    input logic [EW-1:0]     evt_st
);
    logic [ADDR_W-1:0] rel_c;
    assign rel_c = bus_addr - base_addr;

    assert_outside_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_c >= ADDR_W'(16)) |-> (bus_rdata == 8'h00));

    assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((rel_c >= ADDR_W'(12)) && (rel_c < ADDR_W'(16))) |-> (bus_rdata == 8'h00));

    assert_latch_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (rel_c == '0)) |=> (pin_out[7:0] == $past(bus_wdata)));

    assert_set_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_st & ~$past(evt_st) & ~$past(evt_en)) == '0));

    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_en == '0) |-> !event_irq);
endmodule

bind gpio_portfile gpio_portfile_chk #(.ADDR_W(ADDR_W), .EW(gpio_pf_pkg::EVT_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .base_addr (base_addr),
    .pin_out   (pin_out),
    .event_irq (event_irq),
    .evt_en    (en_all),
    .evt_st    (st_all)
);

// File: tb/tb_gpio_portfile.sv
module tb_gpio_portfile;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] base_addr = 16'h0300;
    logic [31:0] pin_in = '0;
    logic [31:0] cfg_oe = '0;
    logic [31:0] pin_out, pin_oe;
    logic        event_irq;

    int checks = 0;
    int fails  = 0;
    logic [7:0] mdl_out [4];

    gpio_portfile dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [3:0] ob(input int p);
        return (p < 2) ? 4'(4 * p) : 4'(8 + 2 * (p - 2));
    endfunction

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr_abs(input logic [15:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        tick();
        bus_wr = 0;
    endtask

    task automatic wr(input logic [3:0] o, input logic [7:0] d);
        wr_abs(base_addr + 16'(o), d);
    endtask

    task automatic rd_abs(input logic [15:0] a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic rd(input logic [3:0] o, output logic [7:0] d);
        rd_abs(base_addr + 16'(o), d);
    endtask

    task automatic settle();
        repeat (3) tick();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        for (int p = 0; p < 4; p++) mdl_out[p] = 8'h00;
        repeat (3) tick();
        rst_n = 1;
        tick();

        // R2/R4: reset state over the whole window
        for (int o = 0; o < 16; o++) begin
            rd(4'(o), v);
            check("R2 R4 reset read", {24'h0, v}, 32'h0);
        end
        check("R7 reset irq", {31'h0, event_irq}, 32'h0);
        check("R2 reset pin_out", pin_out, 32'h0);

        // R2: latch each port with several patterns
        for (int k = 0; k < 4; k++) begin
            for (int p = 0; p < 4; p++) begin
                mdl_out[p] = 8'((p * 37 + k * 91) ^ 8'h5A);
                wr(ob(p), mdl_out[p]);
            end
            for (int p = 0; p < 4; p++) begin
                rd(ob(p), v);
                check("R2 latch readback", {24'h0, v}, {24'h0, mdl_out[p]});
            end
            for (int n = 0; n < 32; n++)
                check("R2 pin map", {31'h0, pin_out[n]}, {31'h0, mdl_out[n >> 3][n & 7]});
        end
        cfg_oe = 32'hA5C3_0F71; #1;
        check("R2 oe pass", pin_oe, 32'hA5C3_0F71);
        cfg_oe = '0;

        // R3: input register follows undriven pins after three edges
        for (int k = 0; k < 6; k++) begin
            pin_in = 32'h1357_9BDF * (k + 1) ^ (32'h1 << (k * 5));
            settle();
            for (int p = 0; p < 4; p++) begin
                rd(ob(p) + 4'd1, v);
                check("R3 input sample", {24'h0, v}, {24'h0, pin_in[p*8 +: 8]});
            end
        end
        // R3: latency, not visible after two edges
        pin_in = 32'h0; settle();
        pin_in = 32'h0000_0001;
        repeat (2) tick();
        rd(4'd1, v);
        check("R3 not yet", {24'h0, v}, 32'h0);
        tick();
        rd(4'd1, v);
        check("R3 third edge", {24'h0, v}, 32'h1);
        // R3: driven pins read their latch
        cfg_oe = 32'h0000_FFFF; pin_in = 32'hFFFF_0000;
        settle();
        for (int p = 0; p < 4; p++) begin
            rd(ob(p) + 4'd1, v);
            check("R3 driven readback", {24'h0, v}, {24'h0, (p < 2) ? mdl_out[p] : 8'hFF});
        end
        cfg_oe = '0; pin_in = '0; settle();

        // R8: reserved and input offsets ignore writes
        for (int o = 12; o < 16; o++) begin
            wr(4'(o), 8'hFF);
            rd(4'(o), v);
            check("R8 reserved", {24'h0, v}, 32'h0);
        end
        for (int p = 0; p < 4; p++) begin
            wr(ob(p) + 4'd1, 8'hC3);
            rd(ob(p) + 4'd1, v);
            check("R8 input write ignored", {24'h0, v}, 32'h0);
            rd(ob(p), v);
            check("R8 latch untouched", {24'h0, v}, {24'h0, mdl_out[p]});
        end

        // R1: window edges with an unaligned base
        base_addr = 16'h1234;
        wr(4'd8, 8'h3C); mdl_out[2] = 8'h3C;
        wr_abs(16'h1244, 8'hEE);
        wr_abs(16'h1233, 8'hDD);
        rd(4'd8, v);
        check("R1 inside write", {24'h0, v}, 32'h3C);
        check("R1 outside no effect", pin_out, {mdl_out[3], mdl_out[2], mdl_out[1], mdl_out[0]});
        rd_abs(16'h1233, v);
        check("R1 below window", {24'h0, v}, 32'h0);
        rd_abs(16'h1244, v);
        check("R1 above window", {24'h0, v}, 32'h0);
        rd_abs(16'h1243, v);
        check("R1 last byte", {24'h0, v}, 32'h0);

        // R4: enable registers
        wr(4'd2, 8'h0F); wr(4'd6, 8'h00);
        rd(4'd2, v); check("R4 enable p0", {24'h0, v}, 32'h0F);
        rd(4'd6, v); check("R4 enable p1", {24'h0, v}, 32'h00);

        // R5: rising edges on enabled bits only
        pin_in = 32'h0000_FFFF; settle();
        rd(4'd3, v); check("R5 status p0", {24'h0, v}, 32'h0F);
        rd(4'd7, v); check("R5 status p1 disabled", {24'h0, v}, 32'h00);
        check("R7 irq raised", {31'h0, event_irq}, 32'h1);
        pin_in = 32'h0; settle();
        rd(4'd3, v); check("R5 falling no change", {24'h0, v}, 32'h0F);

        // R7: masking keeps status
        wr(4'd2, 8'h00); #1;
        check("R7 masked", {31'h0, event_irq}, 32'h0);
        rd(4'd3, v); check("R7 status kept", {24'h0, v}, 32'h0F);
        wr(4'd2, 8'h0F); #1;
        check("R7 unmasked", {31'h0, event_irq}, 32'h1);

        // R6: write one to clear
        wr(4'd3, 8'h05);
        rd(4'd3, v); check("R6 partial clear", {24'h0, v}, 32'h0A);
        wr(4'd3, 8'h00);
        rd(4'd3, v); check("R6 zero write", {24'h0, v}, 32'h0A);
        wr(4'd3, 8'hFF);
        rd(4'd3, v); check("R6 full clear", {24'h0, v}, 32'h00);
        check("R6 irq after clear", {31'h0, event_irq}, 32'h0);

        // R5/R7: port 1 bank
        wr(4'd6, 8'hF0);
        pin_in = 32'h0000_FF00; settle();
        rd(4'd7, v); check("R5 status p1", {24'h0, v}, 32'hF0);
        check("R7 irq p1", {31'h0, event_irq}, 32'h1);
        // R6: set wins over clear in the same cycle
        pin_in = 32'h0; settle();
        wr(4'd7, 8'hFF);
        pin_in = 32'h0000_0100;
        repeat (2) tick();
        bus_addr = base_addr + 16'd7; bus_wdata = 8'h10; bus_wr = 1;
        tick(); bus_wr = 0;
        rd(4'd7, v); check("R6 set beats clear", {24'h0, v}, 32'h00);
        pin_in = 32'h0; settle();
        pin_in = 32'h0000_1000;
        repeat (2) tick();
        bus_addr = base_addr + 16'd7; bus_wdata = 8'h10; bus_wr = 1;
        tick(); bus_wr = 0;
        rd(4'd7, v); check("R6 set beats clear", {24'h0, v}, 32'h10);

        summary();
        $finish;
    end
endmodule